// File: doc/BRIEF.md
# Multi-Source Down Counter-Timer

This block is a programmable down counter for a serial controller. It decrements once for each pulse on the count source picked from eight candidates. Seven of these candidates are generic enable inputs, for example internal clock taps, a prescaled system clock or a synchronised external pin. The eighth is the received-character strobe. When the count passes through zero the block raises a sticky interrupt and updates its timer output. The output is either a square wave that can serve as a spare baud clock, or a one-cycle pulse.

A small write-only host interface holds the preload value and the control settings, and it accepts start, stop and interrupt-clear commands. Three operating modes are available. Timer mode reloads the counter and keeps running. Counter mode halts at zero; together with the character strobe as its source, it counts received characters. Watchdog mode reloads the counter on every received character, so the interrupt fires only after a quiet period on the line.

Top module: `cnt_timer`

## Requirements
- R1: After a synchronous reset, `irq` and `tmr_out` are 0 and the counter is halted until a start command.
- R2: While the counter is running, only the enable that `sel` picks decrements the count. Pulses on the other enables leave the count and outputs unchanged, and so does `rx_char` outside watchdog mode when source 7 is not selected.
- R3: After a start with preload N (1 to 65535), the N-th selected pulse moves the count through zero. This terminal event sets `irq` and is visible in the cycle after that pulse.
- R4: With control bit 5 = 0, `tmr_out` toggles on every terminal event and a start clears it to 0. With bit 5 = 1, `tmr_out` is high for exactly the one cycle after each terminal event.
- R5: A preload of 0 gives a period of 65536 selected pulses.
- R6: Counter mode (mode code 1) halts at zero after its terminal event. Further pulses give no new terminal event until the next start.
- R7: Select code 7 uses `rx_char` as the count source, so the counter counts received characters.
- R8: Watchdog mode (mode code 2) reloads the preload value on every `rx_char` pulse, and the reload takes priority over a coincident count pulse. The interrupt therefore fires only after N pulses with no character in between.
- R9: `irq` stays set until a clear command. When a terminal event and a clear arrive in the same cycle, the interrupt stays set.
- R10: A stop command halts counting and further pulses are ignored. A start command reloads the preload value and counting resumes from it.
- R11: The register map is as follows. Address 0 holds the preload value. Address 1 is control: bits [2:0] select the source, bits [4:3] the mode (0 timer, 1 counter, 2 watchdog, 3 behaves as timer), and bit 5 picks pulse output. Address 2 takes commands: bit 0 start, bit 1 stop, bit 2 clear interrupt. Stop wins over start, and a start wins over a coincident pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 2 | Host register address |
| wr_data | input | 16 | Host write data |
| src_tick | input | 7 | Count-source enables 0 to 6, single-cycle pulses |
| rx_char | input | 1 | Received-character strobe (source 7, watchdog reload) |
| tmr_out | output | 1 | Square-wave or pulse timer output |
| irq | output | 1 | Sticky zero-crossing interrupt |

## Verification
The counter is driven with sparse pulses on the selected enable and with floods on the unselected enables and the character strobe. This shows whether the source decoding isolates one input. A continuously held enable over a full 65536-pulse period checks the zero-preload case, and a preload of 2 with mode code 3 checks back-to-back reloads. Character pulses placed in the middle of a watchdog period tell a reload apart from a decrement. Commands that collide with pulses show the priority of stop over start, start over count, and interrupt set over clear.

// File: rtl/cnt_timer_pkg.sv
package cnt_timer_pkg;

  typedef enum logic [1:0] {
    MD_TIMER = 2'd0,
    MD_COUNT = 2'd1,
    MD_WDOG  = 2'd2,
    MD_ALT   = 2'd3
  } mode_e;

  localparam logic [1:0] A_PRELOAD = 2'd0;
  localparam logic [1:0] A_CTRL    = 2'd1;
  localparam logic [1:0] A_CMD     = 2'd2;

  localparam int CMD_START = 0;
  localparam int CMD_STOP  = 1;
  localparam int CMD_CLEAR = 2;

  localparam int CTL_SEL_LO  = 0;
  localparam int CTL_MODE_LO = 3;
  localparam int CTL_PULSE   = 5;

endpackage

// File: rtl/cnt_timer_regs.sv
module cnt_timer_regs
  import cnt_timer_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] preload,
  output logic [SEL_W-1:0] sel,
  output logic [1:0]       mode,
  output logic             pulse_mode,
  output logic             cmd_start,
  output logic             cmd_stop,
  output logic             cmd_clear
);

  logic cmd_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      preload    <= '0;
      sel        <= '0;
      mode       <= MD_TIMER;
      pulse_mode <= 1'b0;
    end else if (wr_en) begin
      if (wr_addr == A_PRELOAD) preload <= wr_data;
      if (wr_addr == A_CTRL) begin
        sel        <= wr_data[CTL_SEL_LO +: SEL_W];
        mode       <= wr_data[CTL_MODE_LO +: 2];
        pulse_mode <= wr_data[CTL_PULSE];
      end
    end
  end

  assign cmd_wr    = wr_en && (wr_addr == A_CMD);
  assign cmd_start = cmd_wr && wr_data[CMD_START];
  assign cmd_stop  = cmd_wr && wr_data[CMD_STOP];
  assign cmd_clear = cmd_wr && wr_data[CMD_CLEAR];

endmodule

// File: rtl/cnt_timer_srcsel.sv
module cnt_timer_srcsel #(
  parameter int NSRC  = 8,
  parameter int SEL_W = 3
) (
  input  logic [NSRC-2:0] src_tick,
  input  logic            rx_char,
  input  logic [SEL_W-1:0] sel,
  output logic            tick
);

  logic [NSRC-1:0] all_src;
  logic [NSRC-1:0] hit;

  assign all_src = {rx_char, src_tick};

  for (genvar g = 0; g < NSRC; g++) begin : g_match
    assign hit[g] = all_src[g] && (sel == SEL_W'(g));
  end

  assign tick = |hit;

endmodule

// File: rtl/cnt_timer_core.sv
module cnt_timer_core
  import cnt_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] preload,
  input  logic [1:0]       mode,
  input  logic             pulse_mode,
  input  logic             cmd_start,
  input  logic             cmd_stop,
  input  logic             cmd_clear,
  input  logic             tick,
  input  logic             rx_char,
  output logic [CNT_W:0]   cnt_q,
  output logic             run_q,
  output logic             term,
  output logic             irq,
  output logic             tmr_out
);

  localparam logic [CNT_W:0] ONE  = (CNT_W+1)'(1);
  localparam logic [CNT_W:0] FULL = ONE << CNT_W;

  logic [CNT_W:0] load_val;
  logic           wd_reload;
  logic           act;

  assign load_val  = (preload == '0) ? FULL : {1'b0, preload};
  assign act       = run_q && !cmd_start && !cmd_stop;
  assign wd_reload = act && (mode == MD_WDOG) && rx_char;
  assign term      = act && !wd_reload && tick && (cnt_q == ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (cmd_stop) begin
      run_q <= 1'b0;
    end else if (cmd_start) begin
      cnt_q <= load_val;
      run_q <= 1'b1;
    end else if (run_q) begin
      if (wd_reload) begin
        cnt_q <= load_val;
      end else if (tick) begin
        if (cnt_q == ONE) begin
          if (mode == MD_COUNT) begin
            cnt_q <= '0;
            run_q <= 1'b0;
          end else begin
            cnt_q <= load_val;
          end
        end else begin
          cnt_q <= cnt_q - ONE;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq <= 1'b0;
    end else if (term) begin
      irq <= 1'b1;
    end else if (cmd_clear) begin
      irq <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tmr_out <= 1'b0;
    end else if (pulse_mode) begin
      tmr_out <= term;
    end else if (cmd_start && !cmd_stop) begin
      tmr_out <= 1'b0;
    end else if (term) begin
      tmr_out <= ~tmr_out;
    end
  end

endmodule

// File: rtl/cnt_timer.sv
module cnt_timer
  import cnt_timer_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int NSRC  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [NSRC-2:0]  src_tick,
  input  logic             rx_char,
  output logic             tmr_out,
  output logic             irq
);

  localparam int SEL_W = $clog2(NSRC);

  logic [CNT_W-1:0] preload;
  logic [SEL_W-1:0] sel;
  logic [1:0]       mode;
  logic             pulse_mode;
  logic             cmd_start, cmd_stop, cmd_clear;
  logic             tick;
  logic [CNT_W:0]   cnt_q;
  logic             run_q;
  logic             term;

  cnt_timer_regs #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .preload(preload), .sel(sel), .mode(mode), .pulse_mode(pulse_mode),
    .cmd_start(cmd_start), .cmd_stop(cmd_stop), .cmd_clear(cmd_clear)
  );

  cnt_timer_srcsel #(.NSRC(NSRC), .SEL_W(SEL_W)) u_src (
    .src_tick(src_tick), .rx_char(rx_char), .sel(sel), .tick(tick)
  );

  cnt_timer_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .preload(preload), .mode(mode),
    .pulse_mode(pulse_mode), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
    .cmd_clear(cmd_clear), .tick(tick), .rx_char(rx_char),
    .cnt_q(cnt_q), .run_q(run_q), .term(term), .irq(irq), .tmr_out(tmr_out)
  );

endmodule

// File: rtl/cnt_timer_chk.sv
module cnt_timer_chk
  import cnt_timer_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int NSRC  = 8,
  parameter int SEL_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [1:0]       wr_addr,
  input logic [CNT_W-1:0] wr_data,
  input logic [NSRC-2:0]  src_tick,
  input logic             rx_char,
  input logic [SEL_W-1:0] sel,
  input logic [1:0]       mode,
  input logic             pulse_mode,
  input logic [CNT_W:0]   cnt_q,
  input logic             run_q,
  input logic             term,
  input logic             irq,
  input logic             tmr_out
);

  logic [NSRC-1:0] all_src;
  logic            sel_hit;
  logic            clear_wr;

  assign all_src  = {rx_char, src_tick};
  assign sel_hit  = all_src[sel];
  assign clear_wr = wr_en && (wr_addr == A_CMD) && wr_data[CMD_CLEAR];

  // R9
  irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    irq && !clear_wr |=> irq);

  // R6
  count_halt_chk: assert property (@(posedge clk) disable iff (rst)
    term && (mode == MD_COUNT) |=> !run_q && (cnt_q == '0));

  // R2
  idle_src_chk: assert property (@(posedge clk) disable iff (rst)
    run_q && !sel_hit && !wr_en && !(rx_char && mode == MD_WDOG) |=> $stable(cnt_q));

  // R5
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= ((CNT_W+1)'(1) << CNT_W));

  // R4
  square_chk: assert property (@(posedge clk) disable iff (rst)
    term && !pulse_mode |=> tmr_out != $past(tmr_out));

  // R3
  irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(term));

endmodule

bind cnt_timer cnt_timer_chk #(.CNT_W(CNT_W), .NSRC(NSRC), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .src_tick(src_tick), .rx_char(rx_char), .sel(sel), .mode(mode),
  .pulse_mode(pulse_mode), .cnt_q(cnt_q), .run_q(run_q), .term(term),
  .irq(irq), .tmr_out(tmr_out)
);

// File: tb/test_cnt_timer.sv
module test_cnt_timer;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [6:0]  src_tick = '0;
  logic        rx_char = 1'b0;
  logic        tmr_out, irq;

  int checks = 0;
  int fails = 0;
  string cur_req = "R1";

  cnt_timer i_cnt_timer (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .src_tick(src_tick), .rx_char(rx_char), .tmr_out(tmr_out), .irq(irq)
  );

  always #10 clk = ~clk;

  // behavioural reference
  int m_cnt, m_pre, m_sel, m_mode, m_pulse, m_run, m_irq, m_out;
  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_pre = 0; m_sel = 0; m_mode = 0; m_pulse = 0;
      m_run = 0; m_irq = 0; m_out = 0;
    end else begin
      bit st, sp, cl, tk, wdr, trm;
      int ld;
      st  = wr_en && wr_addr == 2 && wr_data[0];
      sp  = wr_en && wr_addr == 2 && wr_data[1];
      cl  = wr_en && wr_addr == 2 && wr_data[2];
      tk  = (m_sel == 7) ? rx_char : src_tick[m_sel];
      ld  = (m_pre == 0) ? 65536 : m_pre;
      wdr = m_run != 0 && !st && !sp && m_mode == 2 && rx_char;
      trm = m_run != 0 && !st && !sp && !wdr && tk && m_cnt == 1;
      if (trm) m_irq = 1; else if (cl) m_irq = 0;
      if (m_pulse != 0) m_out = trm;
      else if (st && !sp) m_out = 0;
      else if (trm) m_out = 1 - m_out;
      if (sp) m_run = 0;
      else if (st) begin m_cnt = ld; m_run = 1; end
      else if (m_run != 0) begin
        if (wdr) m_cnt = ld;
        else if (tk) begin
          if (m_cnt == 1) begin
            if (m_mode == 1) begin m_cnt = 0; m_run = 0; end
            else m_cnt = ld;
          end else m_cnt = m_cnt - 1;
        end
      end
      if (wr_en && wr_addr == 0) m_pre = wr_data;
      if (wr_en && wr_addr == 1) begin
        m_sel = wr_data[2:0]; m_mode = wr_data[4:3]; m_pulse = wr_data[5];
      end
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(input logic [6:0] s, input logic rc, input logic we,
                     input logic [1:0] a, input logic [15:0] d);
    src_tick = s; rx_char = rc; wr_en = we; wr_addr = a; wr_data = d;
    @(negedge clk);
    check(cur_req, "model irq", int'(irq), m_irq);
    check(cur_req, "model tmr_out", int'(tmr_out), m_out);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc('0, 1'b0, 1'b0, 2'd0, '0);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    cyc('0, 1'b0, 1'b1, a, d);
  endtask

  task automatic pulse(input logic [6:0] s, input logic rc, input int n);
    for (int i = 0; i < n; i++) begin
      cyc(s, rc, 1'b0, 2'd0, '0);
      cyc('0, 1'b0, 1'b0, 2'd0, '0);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired, test hung");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    cur_req = "R1";
    idle(2);
    check("R1", "irq after reset", int'(irq), 0);
    check("R1", "tmr_out after reset", int'(tmr_out), 0);
    pulse(7'h7f, 1'b1, 3);
    check("R1", "halted before start", int'(irq), 0);

    // timer, source 2, square output
    cur_req = "R3";
    wr(2'd0, 16'd5);
    wr(2'd1, 16'd2);
    wr(2'd2, 16'd1);
    pulse(7'b0000100, 1'b0, 4);
    check("R3", "irq before N-th pulse", int'(irq), 0);
    pulse(7'b0000100, 1'b0, 1);
    check("R3", "irq at N-th pulse", int'(irq), 1);
    check("R4", "square toggled high", int'(tmr_out), 1);
    cur_req = "R4";
    pulse(7'b0000100, 1'b0, 5);
    check("R4", "square toggled low", int'(tmr_out), 0);
    check("R9", "irq sticky", int'(irq), 1);
    cur_req = "R9";
    wr(2'd2, 16'd4);
    check("R9", "irq cleared", int'(irq), 0);

    cur_req = "R2";
    pulse(7'b1111011, 1'b1, 10);
    check("R2", "other sources ignored irq", int'(irq), 0);
    check("R2", "other sources ignored out", int'(tmr_out), 0);
    pulse(7'b0000100, 1'b0, 5);
    check("R2", "selected source counts", int'(irq), 1);
    wr(2'd2, 16'd4);

    // pulse output
    cur_req = "R4";
    wr(2'd1, 16'd34);
    wr(2'd2, 16'd1);
    pulse(7'b0000100, 1'b0, 4);
    check("R4", "pulse low before terminal", int'(tmr_out), 0);
    cyc(7'b0000100, 1'b0, 1'b0, 2'd0, '0);
    check("R4", "pulse high after terminal", int'(tmr_out), 1);
    idle(1);
    check("R4", "pulse one cycle", int'(tmr_out), 0);

    // preload 0 = 65536
    cur_req = "R5";
    wr(2'd0, 16'd0);
    wr(2'd1, 16'd0);
    wr(2'd2, 16'd5);
    for (int i = 0; i < 65535; i++) cyc(7'b0000001, 1'b0, 1'b0, 2'd0, '0);
    check("R5", "no irq at 65535", int'(irq), 0);
    cyc(7'b0000001, 1'b0, 1'b0, 2'd0, '0);
    check("R5", "irq at 65536", int'(irq), 1);
    idle(1);

    // counter mode, source 1
    cur_req = "R6";
    wr(2'd0, 16'd3);
    wr(2'd1, 16'd9);
    wr(2'd2, 16'd5);
    pulse(7'b0000010, 1'b0, 3);
    check("R6", "irq at zero", int'(irq), 1);
    wr(2'd2, 16'd4);
    pulse(7'b0000010, 1'b0, 10);
    check("R6", "halted at zero", int'(irq), 0);

    // character counting
    cur_req = "R7";
    wr(2'd0, 16'd4);
    wr(2'd1, 16'd15);
    wr(2'd2, 16'd5);
    pulse(7'b1111111, 1'b1, 3);
    check("R7", "three characters", int'(irq), 0);
    pulse(7'b0000000, 1'b1, 1);
    check("R7", "fourth character", int'(irq), 1);

    // watchdog
    cur_req = "R8";
    wr(2'd0, 16'd6);
    wr(2'd1, 16'd17);
    wr(2'd2, 16'd5);
    pulse(7'b0000010, 1'b0, 5);
    pulse(7'b0000010, 1'b1, 1);
    pulse(7'b0000010, 1'b0, 5);
    check("R8", "reloaded by character", int'(irq), 0);
    pulse(7'b0000010, 1'b0, 1);
    check("R8", "silence fires", int'(irq), 1);

    cur_req = "R9";
    wr(2'd2, 16'd4);
    pulse(7'b0000010, 1'b0, 5);
    cyc(7'b0000010, 1'b0, 1'b1, 2'd2, 16'd4);
    check("R9", "set wins over clear", int'(irq), 1);

    // stop and restart
    cur_req = "R10";
    wr(2'd2, 16'd4);
    wr(2'd1, 16'd1);
    wr(2'd0, 16'd3);
    wr(2'd2, 16'd1);
    pulse(7'b0000010, 1'b0, 2);
    wr(2'd2, 16'd2);
    pulse(7'b0000010, 1'b0, 5);
    check("R10", "stopped ignores pulses", int'(irq), 0);
    cur_req = "R11";
    wr(2'd2, 16'd3);
    pulse(7'b0000010, 1'b0, 5);
    check("R11", "stop wins over start", int'(irq), 0);
    cur_req = "R10";
    wr(2'd2, 16'd1);
    pulse(7'b0000010, 1'b0, 2);
    check("R10", "restart reloads", int'(irq), 0);
    pulse(7'b0000010, 1'b0, 1);
    check("R10", "restart period", int'(irq), 1);

    // mode code 3 acts as timer; start beats coincident pulse
    cur_req = "R11";
    wr(2'd2, 16'd4);
    wr(2'd1, 16'd25);
    wr(2'd0, 16'd2);
    cyc(7'b0000010, 1'b0, 1'b1, 2'd2, 16'd1);
    pulse(7'b0000010, 1'b0, 1);
    check("R11", "start beats pulse", int'(irq), 0);
    pulse(7'b0000010, 1'b0, 1);
    check("R11", "mode 3 first period", int'(irq), 1);
    wr(2'd2, 16'd4);
    pulse(7'b0000010, 1'b0, 2);
    check("R11", "mode 3 reloads", int'(irq), 1);
    idle(2);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule